// File: doc/BRIEF.md
# Wired-to-message interrupt converter

This block turns a bank of wired interrupt lines into message-signalled interrupt writes. The lines are grouped into nodes of 128 pins. Each pin has a trigger-type bit that picks level-high or rising-edge detection. Each pin also has a vector entry holding a 10-bit event ID and a 12-bit device ID. When a pin fires it becomes pending. A round-robin arbiter picks one pending pin at a time and presents it on a valid/ready message port. The message carries a doorbell address that is fixed in hardware and a data word made of the pin's IDs.

Software reaches the type and vector registers through a simple 32-bit register port: address, write enable, write data, and combinational read data. A sent pin stays in service and stays silent until software writes a 1 to its bit in a flat clear bitmap. That bitmap is indexed by the global interrupt number. Global numbers 0 to 63 are reserved. Pin index i (input bit i) has global number 64+i and lives in node window (i/128)+1, so window 0 never holds pins. The parameter NODES sets how many node windows exist. It defaults to 2 and must be at most 9, so that the node windows stay clear of the bitmap at 0xA000.

Top module: `wired_msg_conv`

## Requirements
- R1: After reset, msg_valid is 0 and every type and vector register reads 0.
- R2: The type word of node k (1..NODES) for pins 32w..32w+31 of that node is at k*0x1000 + w*4, w = 0..3. Bit b of that word is pin 32w+b. A 1 selects level-high and a 0 selects rising-edge, and the word reads back as written. Reads return 0 and writes are ignored in four cases: node window 0, nodes above NODES, offsets that are not defined, and addresses with bits [1:0] not zero.
- R3: The vector entry of pin p in node k is at k*0x1000 + 0x200 + p*4. Bits [21:12] are the event ID and bits [11:0] are the device ID. Bits [31:22] read as 0.
- R4: A rising-edge pin becomes pending when its input is high in a cycle after a cycle where it was low. An input that stays high creates no further event.
- R5: A level pin becomes pending in any cycle its input is high and it is not in service. It becomes pending again in the same cycle its status is cleared if the input is still high.
- R6: A pin chosen for the message port leaves pending and enters in service. While in service, its input causes no message until its status is cleared.
- R7: Writing the word at 0xA000 + (n/32)*4 clears the status (pending and in service) of every pin whose global number n has a 1 at bit n mod 32. Bits written as 0, words outside the implemented pins, and the reserved words 0xA000 and 0xA004 have no effect. Clearing a pending pin that has not been sent discards it, and a pin being cleared is not chosen in that cycle.
- R8: msg_addr always equals the DOORBELL parameter. msg_data is {10'b0, event ID, device ID}, taken from the winner's vector entry at the edge it is chosen. A message appears the clock after the pin becomes pending.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_data stays stable, even if the vector entry is rewritten. A new pin may be chosen in the cycle that msg_ready is 1.
- R10: Arbitration is round-robin by pin index. The next winner is the first eligible pending pin above the last winner, wrapping to index 0. After reset the search starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NODES*128 | Wired interrupt lines, bit i is global number 64+i |
| reg_addr | input | 16 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 32 | Doorbell address |
| msg_data | output | 32 | Message data {event ID, device ID} |

## Verification
The hardest states to reach combine a stalled message port with status clears. The first is a clear of a pin that is pending but not yet chosen, which must discard it. The second is a vector rewrite of the pin being presented, which must not change the data. The stimulus gets there by holding msg_ready low while several lines rise at once, so one pin waits in the output register and the others wait as pending. Clears, no-effect clear words and vector writes are then issued before ready is released. Wrap-around in the round-robin order is reached by serving a high-index pin first and then raising pins both above and below it.

// File: rtl/wired_msg_conv.sv
module wired_msg_conv #(
  parameter int NODES = 2,
  parameter logic [31:0] DOORBELL = 32'h0004_0040
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NODES*128-1:0]   irq_in,
  input  logic [15:0]            reg_addr,
  input  logic                   reg_we,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [31:0]            msg_addr,
  output logic [31:0]            msg_data
);
  localparam int NP = NODES * 128;
  localparam int IW = $clog2(NP);
  localparam int NW = NP / 32;

  logic [NP-1:0] typ, pend, insv, irq_q;
  logic [21:0]   vec [NP];
  logic [IW-1:0] ptr;

  logic [3:0]  node;
  logic [11:0] off;
  logic        aligned, node_ok, typ_hit, vec_hit, clr_hit;
  logic [IW-1:0] t_base, v_idx, c_base;

  assign node    = reg_addr[15:12];
  assign off     = reg_addr[11:0];
  assign aligned = reg_addr[1:0] == 2'b00;
  assign node_ok = aligned && node != 4'd0 && 32'(node) <= NODES;
  assign typ_hit = node_ok && off[11:4] == 8'd0;
  assign vec_hit = node_ok && off[11:9] == 3'b001;
  assign clr_hit = aligned && node == 4'hA && 32'(reg_addr[11:2]) >= 2 &&
                   32'(reg_addr[11:2]) < 2 + NW;
  assign t_base  = IW'(32'(node - 4'd1) * 128 + 32'(off[3:2]) * 32);
  assign v_idx   = IW'(32'(node - 4'd1) * 128 + 32'(off[8:2]));
  assign c_base  = IW'((32'(reg_addr[11:2]) - 2) * 32);

  always_comb begin
    reg_rdata = '0;
    if (typ_hit)      reg_rdata = typ[t_base +: 32];
    else if (vec_hit) reg_rdata = {10'd0, vec[v_idx]};
  end

  logic [NP-1:0] clr_v, set, keep, elig, win_oh;
  always_comb begin
    clr_v = '0;
    if (reg_we && clr_hit) clr_v[c_base +: 32] = reg_wdata;
  end

  assign set  = (typ & irq_in) | (~typ & irq_in & ~irq_q);
  assign keep = insv & ~clr_v;
  assign elig = pend & ~clr_v;

  logic [IW-1:0] win_lo, win_hi, win;
  logic          hi_found, any, load;
  always_comb begin
    win_lo   = '0;
    win_hi   = '0;
    hi_found = 1'b0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (elig[i]) win_lo = IW'(i);
      if (elig[i] && IW'(i) > ptr) begin
        win_hi   = IW'(i);
        hi_found = 1'b1;
      end
    end
  end
  assign win  = hi_found ? win_hi : win_lo;
  assign any  = |elig;
  assign load = any && (!msg_valid || msg_ready);

  always_comb begin
    win_oh = '0;
    if (load) win_oh[win] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ <= '0;
      for (int i = 0; i < NP; i++) vec[i] <= '0;
    end else if (reg_we) begin
      if (typ_hit) typ[t_base +: 32] <= reg_wdata;
      if (vec_hit) vec[v_idx] <= reg_wdata[21:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
      insv  <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= ((pend & ~clr_v) | (set & ~keep)) & ~win_oh;
      insv  <= keep | win_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      ptr       <= IW'(NP - 1);
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_data  <= {10'd0, vec[win]};
      ptr       <= win;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  assign msg_addr = DOORBELL;

  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid);
  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> $stable(msg_data));
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & insv) == '0);
  a_r10_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> elig[win]);
  a_r2_window0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    node == 4'd0 |-> reg_rdata == 32'd0);
  a_r7_cleared_idle: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_v |=> ((pend | insv) & $past(clr_v & ~set)) == '0);
endmodule

// File: tb/sim_wired_msg_conv.sv
module sim_wired_msg_conv;
  localparam int NODES = 2;
  localparam int NP = NODES * 128;
  localparam int NW = NP / 32;
  localparam logic [31:0] DB = 32'h0004_0040;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] irq_in = '0;
  logic [15:0] reg_addr = '0;
  logic reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, msg_addr, msg_data;
  logic msg_valid, msg_ready = 1;

  wired_msg_conv #(.NODES(NODES), .DOORBELL(DB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data));

  always #5 clk = ~clk;

  bit [NP-1:0] m_typ, m_pend, m_insv, m_irqq;
  bit [21:0] m_vec [NP];
  int m_ptr;
  bit m_valid;
  bit [31:0] m_data;
  int vectors = 0, errors = 0;
  string tag = "R1";

  function automatic bit [31:0] mread(bit [15:0] a);
    int nd = int'(a) / 4096, of = int'(a) % 4096;
    bit [31:0] r = 0;
    if (a[1:0] == 0 && nd >= 1 && nd <= NODES) begin
      if (of < 16)
        for (int b = 0; b < 32; b++) r[b] = m_typ[(nd-1)*128 + (of/4)*32 + b];
      else if (of >= 512 && of < 1024)
        r = {10'd0, m_vec[(nd-1)*128 + (of-512)/4]};
    end
    return r;
  endfunction

  function automatic void model_step();
    bit [NP-1:0] clr = 0, st, nxp, nxi;
    int w = -1, a = int'(reg_addr);
    bit can;
    if (reg_we && a % 4 == 0 && a >= 'hA008 && a < 'hA000 + 4*(2+NW))
      for (int b = 0; b < 32; b++) clr[(a - 'hA000)/4*32 + b - 64] = reg_wdata[b];
    for (int i = 0; i < NP; i++)
      st[i] = m_typ[i] ? irq_in[i] : (irq_in[i] && !m_irqq[i]);
    can = !m_valid || msg_ready;
    for (int k = 1; k <= NP; k++) begin
      int j = (m_ptr + k) % NP;
      if (w < 0 && m_pend[j] && !clr[j]) w = j;
    end
    if (!can) w = -1;
    for (int i = 0; i < NP; i++) begin
      bit kp = m_insv[i] && !clr[i];
      nxp[i] = ((m_pend[i] && !clr[i]) || (st[i] && !kp)) && (i != w);
      nxi[i] = kp || (i == w);
    end
    if (w >= 0) begin
      m_valid = 1; m_data = {10'd0, m_vec[w]}; m_ptr = w;
    end else if (msg_ready) m_valid = 0;
    m_pend = nxp; m_insv = nxi; m_irqq = irq_in;
    if (reg_we && a % 4 == 0 && a / 4096 >= 1 && a / 4096 <= NODES) begin
      int nd = a / 4096, of = a % 4096;
      if (of < 16)
        for (int b = 0; b < 32; b++) m_typ[(nd-1)*128 + (of/4)*32 + b] = reg_wdata[b];
      else if (of >= 512 && of < 1024)
        m_vec[(nd-1)*128 + (of-512)/4] = reg_wdata[21:0];
    end
  endfunction

  task automatic compare();
    bit [31:0] er = mread(reg_addr);
    vectors++;
    if (msg_valid !== m_valid || (m_valid && msg_data !== m_data) ||
        msg_addr !== DB || reg_rdata !== er) begin
      errors++;
      $display("FAIL %s t=%0t valid=%b/%b data=%h/%h addr=%h/%h rdata=%h/%h (actual/expected)",
               tag, $time, msg_valid, m_valid, msg_data, m_data, msg_addr, DB, reg_rdata, er);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit [15:0] a, bit [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(bit [15:0] a);
    reg_addr = a;
    tick();
  endtask

  function automatic bit [15:0] vaddr(int i);
    return 16'((i/128 + 1)*4096 + 512 + (i%128)*4);
  endfunction
  function automatic bit [15:0] taddr(int i);
    return 16'((i/128 + 1)*4096 + ((i%128)/32)*4);
  endfunction
  function automatic bit [15:0] caddr(int i);
    return 16'('hA000 + ((i+64)/32)*4);
  endfunction

  task automatic set_type(int i, bit lvl);
    bit [31:0] w = mread(taddr(i));
    w[i%32] = lvl;
    wr(taddr(i), w);
  endtask
  task automatic clear(int i);
    wr(caddr(i), 32'd1 << ((i+64)%32));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_ptr = NP - 1;
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1;
    tag = "R1";
    idle(2);
    rd(16'h1000); rd(16'h1204); rd(16'h23FC); rd(16'h200C);

    tag = "R2";
    wr(16'h1004, 32'hA5A5_0F0F); rd(16'h1004);
    wr(16'h200C, 32'h8000_0001); rd(16'h200C);
    wr(16'h0004, 32'hFFFF_FFFF); rd(16'h0004);
    wr(16'h3000, 32'hFFFF_FFFF); rd(16'h3000);
    wr(16'h1010, 32'h1234_5678); rd(16'h1010);
    wr(16'h1006, 32'hFFFF_FFFF); rd(16'h1004); rd(16'h1006);
    for (int k = 1; k <= NODES; k++)
      for (int w = 0; w < 4; w++) wr(16'(k*4096 + w*4), 32'd0);
    rd(16'h1004);

    tag = "R3";
    wr(vaddr(255), 32'hFFFF_FFFF); rd(vaddr(255));
    wr(16'h0200, 32'h0000_0ABC); rd(16'h0200);
    for (int i = 0; i < NP; i += 5) wr(vaddr(i), 32'((i*37) << 12 | (i*11 + 3)));
    wr(vaddr(255), 32'h0015_5FFF);
    rd(vaddr(5)); rd(vaddr(130));

    tag = "R4 R8";
    irq_in[5] = 1; idle(6);
    clear(5); idle(4);
    irq_in[5] = 0; idle(2); clear(5);
    irq_in[5] = 1; idle(4);
    irq_in[5] = 0; clear(5); idle(2);

    tag = "R5";
    set_type(40, 1); wr(vaddr(40), 32'h0012_3456);
    irq_in[40] = 1; idle(5);
    clear(40); idle(5);
    irq_in[40] = 0; clear(40); idle(4);

    tag = "R6";
    irq_in[130] = 1; idle(3);
    irq_in[130] = 0; idle(1); irq_in[130] = 1; idle(3);
    irq_in[130] = 0; clear(130); idle(2);
    irq_in[130] = 1; idle(3); irq_in[130] = 0; clear(130); idle(1);

    tag = "R7";
    msg_ready = 0;
    irq_in[10] = 1; irq_in[11] = 1; irq_in[12] = 1; idle(3);
    clear(11);
    wr(caddr(12), 32'd0);
    wr(16'hA000, 32'hFFFF_FFFF); wr(16'hA004, 32'hFFFF_FFFF);
    wr(16'hA028, 32'hFFFF_FFFF);
    idle(2);
    msg_ready = 1; idle(4);
    irq_in[10] = 0; irq_in[11] = 0; irq_in[12] = 0;
    wr(caddr(10), 32'h0);
    irq_in[10] = 1; idle(3); irq_in[10] = 0;
    wr(caddr(10), 32'hFFFF_FFFF); idle(2);

    tag = "R9";
    msg_ready = 0;
    irq_in[20] = 1; irq_in[255] = 1; idle(4);
    wr(vaddr(20), 32'h003F_FFFF); wr(vaddr(255), 32'h0);
    idle(3); msg_ready = 1; idle(1); msg_ready = 0; idle(3);
    msg_ready = 1; idle(3);
    irq_in[20] = 0; irq_in[255] = 0;
    clear(20); clear(255); idle(2);

    tag = "R10";
    irq_in[3] = 1; irq_in[100] = 1; irq_in[200] = 1; irq_in[201] = 1; idle(8);
    irq_in = '0; idle(1);
    for (int w = 2; w < 2 + NW; w++) wr(16'('hA000 + w*4), 32'hFFFF_FFFF);
    msg_ready = 0;
    irq_in[200] = 1; idle(3);
    irq_in[3] = 1; irq_in[250] = 1; irq_in[199] = 1; idle(2);
    msg_ready = 1; idle(6);
    irq_in = '0;
    for (int w = 2; w < 2 + NW; w++) wr(16'('hA000 + w*4), 32'hFFFF_FFFF);
    idle(3);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule